// File: doc/BRIEF.md
# Auto-Acknowledge Receive State Controller

This block sequences a radio receiver's auto-acknowledge listen mode. It waits for frames, judges each completed frame from an address-filter flag and a checksum flag, raises a frame-end interrupt for good frames, and when a good frame asks for an acknowledgement it launches the acknowledgement transmitter with a one-cycle start pulse. A 3-bit transaction code tells software how the last transaction ended.

One asynchronous trigger pin has two jobs. In unslotted operation a rising edge on it parks the controller in a quiet listen state in which the clock-output enable is dropped. A falling edge, or the arrival of a good frame, brings the clock back. In slotted operation the pin never gates the clock. Instead its rising edge is the launch command for a pending acknowledgement. That launch is not released until a minimum number of symbol ticks has passed since the frame end. A trigger that comes too early is remembered and acted on once the minimum is reached.

The pin passes through a synchronizer and edge detectors before the state machine sees it. The PHY, the checksum unit, the frame parser and the modulator sit outside the block. They appear only as strobes: frame end, symbol tick and acknowledgement done.

Top module: `aack_rx_ctrl`

## Requirements
- R1: After reset the clock-output enable is 1, the ack-start pulse and the frame interrupt are 0, and the transaction code is 7 (idle/invalid).
- R2: With slotted mode off and the controller listening, a rising edge on the trigger pin drops the clock-output enable within five clock cycles.
- R3: While the clock is gated, a falling edge on the trigger pin restores the clock-output enable within five cycles.
- R4: A frame is good only when both the filter flag and the checksum flag are 1 at the frame-end strobe. A good frame gives a frame interrupt of exactly one cycle, in the cycle after the strobe. A bad frame gives no interrupt and leaves a gated clock gated.
- R5: A good frame arriving while the clock is gated turns the clock back on. After that transaction the clock stays on even with the pin still high, and gating resumes only on a fresh rising edge.
- R6: In unslotted mode, a good frame requesting an acknowledgement produces exactly one single-cycle ack-start pulse, two cycles after the frame-end strobe.
- R7: A good frame that requests no acknowledgement produces no ack-start pulse and sets the transaction code to 0 (success).
- R8: With slotted mode on, trigger-pin edges never drop the clock-output enable.
- R9: In slotted mode, an acknowledgement is held until a rising edge on the trigger pin. While it waits, the transaction code reads 1 (success, waiting for trigger).
- R10: In slotted mode, the ack-start pulse never comes before 3 symbol ticks have been counted after the frame-end strobe. A trigger edge that arrives earlier is held and served once the third tick has passed.
- R11: One cycle after an ack-done strobe ends an acknowledgement, the controller is listening with the clock on and the transaction code reads 0.
- R12: A bad frame sets the transaction code to 7. The code only ever takes the values 0, 1 or 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_pin | input | 1 | Asynchronous trigger pin: clock gate in unslotted mode, ack launch in slotted mode |
| frame_end | input | 1 | One-cycle strobe marking the last symbol of a received frame |
| filt_ok | input | 1 | Address filter passed, valid with frame_end |
| fcs_ok | input | 1 | Checksum correct, valid with frame_end |
| ack_req | input | 1 | Frame asks for an acknowledgement, valid with frame_end |
| slotted_mode | input | 1 | Configuration: 1 selects slotted acknowledgement operation |
| sym_tick | input | 1 | One-cycle pulse per symbol period |
| ack_done | input | 1 | One-cycle strobe from the transmitter when the acknowledgement is sent |
| clk_out_en | output | 1 | Enable for the external clock output |
| ack_start | output | 1 | One-cycle pulse that starts acknowledgement transmission |
| frame_irq | output | 1 | One-cycle frame-end interrupt for good frames |
| trac_code | output | 3 | Transaction code: 0 success, 1 waiting for trigger, 7 idle/invalid |

## Verification
The hardest case to reach from the ports is a slotted acknowledgement whose trigger edge comes before the symbol minimum has passed. The edge has to land inside the short window between the frame end and the third tick, and it has to pass through the synchronizer first. The stimulus raises the pin straight after the frame end and only then supplies ticks, with random gaps between them. A monitor counts the ticks driven since the frame end and checks every ack-start pulse against that count. Random transactions with mixed filter, checksum, request and mode bits then cover the ordinary paths.

// File: rtl/aack_pkg.sv
package aack_pkg;

    typedef enum logic [2:0] {
        ST_LISTEN       = 3'd0,
        ST_LISTEN_GATED = 3'd1,
        ST_RX_EVAL      = 3'd2,
        ST_ACK_WAIT     = 3'd3,
        ST_ACK_TX       = 3'd4
    } aack_state_t;

    typedef logic [2:0] trac_t;

    localparam trac_t TRAC_OK   = 3'd0;
    localparam trac_t TRAC_WAIT = 3'd1;
    localparam trac_t TRAC_IDLE = 3'd7;

    typedef struct packed {
        logic good;
        logic want_ack;
    } frame_info_t;

    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } trig_ev_t;

    function automatic frame_info_t judge_frame(input logic filt, input logic fcs,
                                                input logic req);
        frame_info_t f;
        f.good     = filt & fcs;
        f.want_ack = req;
        return f;
    endfunction

    function automatic logic is_listening(input aack_state_t s);
        return (s == ST_LISTEN) || (s == ST_LISTEN_GATED);
    endfunction

endpackage

// File: rtl/trig_edge_sync.sv
module trig_edge_sync
    import aack_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     pin_async,
    output trig_ev_t ev
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] stage_q;
    logic                   prev_q;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
            logic q;
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) q <= 1'b0;
                    else     q <= pin_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) q <= 1'b0;
                    else     q <= g_stage[g-1].q;
                end
            end
            assign stage_q[g] = q;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= stage_q[LAST];
    end

    always_comb begin
        ev.level = stage_q[LAST];
        ev.rise  = stage_q[LAST] & ~prev_q;
        ev.fall  = ~stage_q[LAST] & prev_q;
    end
endmodule

// File: rtl/symbol_hold_timer.sv
module symbol_hold_timer #(
    parameter int HOLD_SYMS = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic tick,
    output logic ready
);
    localparam int CW = $clog2(HOLD_SYMS + 1) + 1;
    localparam logic [CW-1:0] LIMIT = CW'(HOLD_SYMS);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                        cnt_q <= '0;
        else if (clear)                 cnt_q <= '0;
        else if (tick && cnt_q < LIMIT) cnt_q <= cnt_q + 1'b1;
    end

    assign ready = (cnt_q >= LIMIT);
endmodule

// File: rtl/aack_fsm.sv
module aack_fsm
    import aack_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  trig_ev_t    ev,
    input  logic        frame_end,
    input  frame_info_t finfo,
    input  logic        slotted,
    input  logic        hold_ready,
    input  logic        ack_done,
    output logic        timer_clear,
    output logic        clk_en,
    output logic        ack_pulse,
    output logic        irq_pulse,
    output trac_t       trac
);
    aack_state_t st_q, st_n;
    frame_info_t info_q, info_n;
    logic        origin_gated_q, origin_gated_n;
    logic        pend_q, pend_n;
    logic        ack_q, ack_n;
    logic        irq_q, irq_n;
    trac_t       trac_q, trac_n;

    always_comb begin
        st_n           = st_q;
        info_n         = info_q;
        origin_gated_n = origin_gated_q;
        pend_n         = pend_q;
        ack_n          = 1'b0;
        irq_n          = 1'b0;
        trac_n         = trac_q;

        unique case (st_q)
            ST_LISTEN: begin
                if (frame_end) begin
                    st_n           = ST_RX_EVAL;
                    info_n         = finfo;
                    origin_gated_n = 1'b0;
                    irq_n          = finfo.good;
                end else if (ev.rise && !slotted) begin
                    st_n = ST_LISTEN_GATED;
                end
            end
            ST_LISTEN_GATED: begin
                if (frame_end) begin
                    st_n           = ST_RX_EVAL;
                    info_n         = finfo;
                    origin_gated_n = !ev.fall && !slotted;
                    irq_n          = finfo.good;
                end else if (slotted || ev.fall) begin
                    st_n = ST_LISTEN;
                end
            end
            ST_RX_EVAL: begin
                pend_n = ev.rise;
                if (!info_q.good) begin
                    trac_n = TRAC_IDLE;
                    st_n   = (origin_gated_q && !slotted) ? ST_LISTEN_GATED : ST_LISTEN;
                end else if (!info_q.want_ack) begin
                    trac_n = TRAC_OK;
                    st_n   = ST_LISTEN;
                end else if (slotted) begin
                    trac_n = TRAC_WAIT;
                    st_n   = ST_ACK_WAIT;
                end else begin
                    st_n  = ST_ACK_TX;
                    ack_n = 1'b1;
                end
            end
            ST_ACK_WAIT: begin
                if (ev.rise) pend_n = 1'b1;
                if (hold_ready && (pend_q || ev.rise)) begin
                    st_n   = ST_ACK_TX;
                    ack_n  = 1'b1;
                    pend_n = 1'b0;
                end
            end
            ST_ACK_TX: begin
                if (ack_done) begin
                    st_n   = ST_LISTEN;
                    trac_n = TRAC_OK;
                end
            end
            default: st_n = ST_LISTEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q           <= ST_LISTEN;
            info_q         <= '0;
            origin_gated_q <= 1'b0;
            pend_q         <= 1'b0;
            ack_q          <= 1'b0;
            irq_q          <= 1'b0;
            trac_q         <= TRAC_IDLE;
        end else begin
            st_q           <= st_n;
            info_q         <= info_n;
            origin_gated_q <= origin_gated_n;
            pend_q         <= pend_n;
            ack_q          <= ack_n;
            irq_q          <= irq_n;
            trac_q         <= trac_n;
        end
    end

    assign timer_clear = frame_end && is_listening(st_q);
    assign clk_en      = !((st_q == ST_LISTEN_GATED) ||
                           (st_q == ST_RX_EVAL && origin_gated_q));
    assign ack_pulse   = ack_q;
    assign irq_pulse   = irq_q;
    assign trac        = trac_q;
endmodule

// File: rtl/aack_rx_ctrl.sv
module aack_rx_ctrl
    import aack_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_SYMS   = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       trig_pin,
    input  logic       frame_end,
    input  logic       filt_ok,
    input  logic       fcs_ok,
    input  logic       ack_req,
    input  logic       slotted_mode,
    input  logic       sym_tick,
    input  logic       ack_done,
    output logic       clk_out_en,
    output logic       ack_start,
    output logic       frame_irq,
    output logic [2:0] trac_code
);
    trig_ev_t    trig_ev;
    frame_info_t finfo;
    logic        hold_ready;
    logic        timer_clear;
    trac_t       trac_w;

    assign finfo = judge_frame(filt_ok, fcs_ok, ack_req);

    trig_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .pin_async (trig_pin),
        .ev        (trig_ev)
    );

    symbol_hold_timer #(.HOLD_SYMS(HOLD_SYMS)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clear (timer_clear),
        .tick  (sym_tick),
        .ready (hold_ready)
    );

    aack_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .ev          (trig_ev),
        .frame_end   (frame_end),
        .finfo       (finfo),
        .slotted     (slotted_mode),
        .hold_ready  (hold_ready),
        .ack_done    (ack_done),
        .timer_clear (timer_clear),
        .clk_en      (clk_out_en),
        .ack_pulse   (ack_start),
        .irq_pulse   (frame_irq),
        .trac        (trac_w)
    );

    assign trac_code = trac_w;
endmodule

// File: rtl/aack_rx_ctrl_chk.sv
module aack_rx_ctrl_chk #(
    parameter int HOLD_SYMS = 3
) (
    input logic       clk,
    input logic       rst,
    input logic       frame_end,
    input logic       filt_ok,
    input logic       fcs_ok,
    input logic       slotted_mode,
    input logic       sym_tick,
    input logic       clk_out_en,
    input logic       ack_start,
    input logic       frame_irq,
    input logic [2:0] trac_code
);
    localparam int CW = $clog2(HOLD_SYMS + 1) + 1;

    logic [CW-1:0] seen_ticks;

    always_ff @(posedge clk) begin
        if (rst)                                     seen_ticks <= '0;
        else if (frame_irq)                          seen_ticks <= '0;
        else if (sym_tick && seen_ticks < CW'(HOLD_SYMS)) seen_ticks <= seen_ticks + 1'b1;
    end

    AST_ACK_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        ack_start |=> !ack_start); // R6

    AST_IRQ_NEEDS_GOOD_FRAME: assert property (@(posedge clk) disable iff (rst)
        frame_irq |-> $past(frame_end && filt_ok && fcs_ok)); // R4

    AST_SLOTTED_NEVER_GATES: assert property (@(posedge clk) disable iff (rst)
        (slotted_mode && $past(slotted_mode)) |-> clk_out_en); // R8

    AST_SLOTTED_ACK_AFTER_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ack_start && $past(slotted_mode)) |-> (seen_ticks >= CW'(HOLD_SYMS))); // R10

    AST_SLOTTED_ACK_FROM_WAIT: assert property (@(posedge clk) disable iff (rst)
        (ack_start && $past(slotted_mode)) |-> ($past(trac_code) == 3'd1)); // R9

    AST_TRAC_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (trac_code == 3'd0) || (trac_code == 3'd1) || (trac_code == 3'd7)); // R12
endmodule

bind aack_rx_ctrl aack_rx_ctrl_chk #(.HOLD_SYMS(HOLD_SYMS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .frame_end    (frame_end),
    .filt_ok      (filt_ok),
    .fcs_ok       (fcs_ok),
    .slotted_mode (slotted_mode),
    .sym_tick     (sym_tick),
    .clk_out_en   (clk_out_en),
    .ack_start    (ack_start),
    .frame_irq    (frame_irq),
    .trac_code    (trac_code)
);

// File: tb/tb_aack_rx_ctrl.sv
`timescale 1ns/1ps
module tb_aack_rx_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic trig_pin = 0, frame_end = 0, filt_ok = 0, fcs_ok = 0, ack_req = 0;
    logic slotted_mode = 0, sym_tick = 0, ack_done = 0;
    logic clk_out_en, ack_start, frame_irq;
    logic [2:0] trac_code;

    int n_checks = 0;
    int n_fail   = 0;
    int ack_cnt  = 0;
    int irq_cnt  = 0;
    int ticks_since = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    aack_rx_ctrl dut (
        .clk(clk), .rst(rst), .trig_pin(trig_pin), .frame_end(frame_end),
        .filt_ok(filt_ok), .fcs_ok(fcs_ok), .ack_req(ack_req),
        .slotted_mode(slotted_mode), .sym_tick(sym_tick), .ack_done(ack_done),
        .clk_out_en(clk_out_en), .ack_start(ack_start), .frame_irq(frame_irq),
        .trac_code(trac_code)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit exp_good(input bit f, input bit c);
        return f & c;
    endfunction

    function automatic int exp_final_trac(input bit good);
        return good ? 0 : 7;
    endfunction

    // monitor: counts pulses, checks the slotted hold window (R10)
    always @(negedge clk) begin
        if (!rst) begin
            if (ack_start) begin
                ack_cnt++;
                if (slotted_mode) check(ticks_since >= 3, "R10 ack after hold", ticks_since, 3);
            end
            if (frame_irq) irq_cnt++;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_pin(input bit v);
        trig_pin = v;
        cyc(5);
    endtask

    task automatic send_frame(input bit f, input bit c, input bit a);
        frame_end = 1; filt_ok = f; fcs_ok = c; ack_req = a;
        ticks_since = 0;
        @(negedge clk);
        frame_end = 0; filt_ok = 0; fcs_ok = 0; ack_req = 0;
    endtask

    task automatic tick();
        sym_tick = 1;
        @(negedge clk);
        sym_tick = 0;
        ticks_since++;
    endtask

    task automatic finish_ack();
        ack_done = 1;
        @(negedge clk);
        ack_done = 0;
        check(trac_code == 0, "R11 trac one cycle after done", trac_code, 0);
        check(clk_out_en == 1, "R11 clock on after done", clk_out_en, 1);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            summary();
        end
    end

    initial begin
        int a0, i0;
        void'($urandom(32'h5EED_0A11));
        cyc(3);
        rst = 0;
        @(negedge clk);
        // R1
        check(clk_out_en == 1, "R1 clk_out_en", clk_out_en, 1);
        check(ack_start == 0, "R1 ack_start", ack_start, 0);
        check(frame_irq == 0, "R1 frame_irq", frame_irq, 0);
        check(trac_code == 7, "R1 trac_code", trac_code, 7);

        // R2 / R3
        set_pin(1);
        check(clk_out_en == 0, "R2 gate on rise", clk_out_en, 0);
        set_pin(0);
        check(clk_out_en == 1, "R3 ungate on fall", clk_out_en, 1);

        // R4 / R12 bad frame while gated
        set_pin(1);
        i0 = irq_cnt;
        send_frame(1, 0, 1);
        cyc(3);
        check(irq_cnt == i0, "R4 no irq for bad frame", irq_cnt - i0, 0);
        check(clk_out_en == 0, "R4 gated stays gated", clk_out_en, 0);
        check(trac_code == 7, "R12 bad frame code", trac_code, 7);

        // R4 pulse width, R5, R7
        i0 = irq_cnt; a0 = ack_cnt;
        send_frame(1, 1, 0);
        check(frame_irq == 1, "R4 irq in cycle after strobe", frame_irq, 1);
        @(negedge clk);
        check(frame_irq == 0, "R4 irq single cycle", frame_irq, 0);
        cyc(2);
        check(clk_out_en == 1, "R5 good frame ungates", clk_out_en, 1);
        check(trac_code == 0, "R7 success code", trac_code, 0);
        check(ack_cnt == a0, "R7 no ack pulse", ack_cnt - a0, 0);
        cyc(5);
        check(clk_out_en == 1, "R5 stays on with pin high", clk_out_en, 1);
        set_pin(0);
        check(clk_out_en == 1, "R5 fall in listen harmless", clk_out_en, 1);
        set_pin(1);
        check(clk_out_en == 0, "R5 fresh rise gates", clk_out_en, 0);

        // R6 unslotted ack from gated
        a0 = ack_cnt;
        send_frame(1, 1, 1);
        check(ack_start == 0, "R6 no pulse one cycle after", ack_start, 0);
        @(negedge clk);
        check(ack_start == 1, "R6 pulse two cycles after", ack_start, 1);
        cyc(3);
        check(ack_cnt == a0 + 1, "R6 exactly one pulse", ack_cnt - a0, 1);
        finish_ack();
        cyc(5);
        check(clk_out_en == 1, "R5 on after ack with pin high", clk_out_en, 1);
        set_pin(0);

        // R8 slotted never gates
        slotted_mode = 1;
        cyc(2);
        set_pin(1);
        check(clk_out_en == 1, "R8 no gating in slotted", clk_out_en, 1);
        set_pin(0);
        check(clk_out_en == 1, "R8 no gating in slotted (fall)", clk_out_en, 1);

        // R10 early trigger held
        a0 = ack_cnt;
        send_frame(1, 1, 1);
        trig_pin = 1;
        cyc(10);
        check(ack_cnt == a0, "R10 no ack before ticks", ack_cnt - a0, 0);
        tick(); cyc(2); tick(); cyc(4);
        check(ack_cnt == a0, "R10 no ack after two ticks", ack_cnt - a0, 0);
        tick();
        cyc(3);
        check(ack_cnt == a0 + 1, "R10 held trigger served", ack_cnt - a0, 1);
        finish_ack();
        set_pin(0);

        // R9 waiting for trigger
        a0 = ack_cnt;
        send_frame(1, 1, 1);
        repeat (5) begin tick(); cyc(1); end
        cyc(10);
        check(trac_code == 1, "R9 waiting code", trac_code, 1);
        check(ack_cnt == a0, "R9 no ack without trigger", ack_cnt - a0, 0);
        set_pin(1);
        check(ack_cnt == a0 + 1, "R9 trigger launches ack", ack_cnt - a0, 1);
        check(trac_code == 1, "R9 code held until done", trac_code, 1);
        finish_ack();
        set_pin(0);

        // random transactions
        for (int it = 0; it < 40; it++) begin
            bit sl, f, c, rq, early, good;
            sl = $urandom_range(0, 1); f = $urandom_range(0, 3) != 0;
            c = $urandom_range(0, 3) != 0; rq = $urandom_range(0, 1);
            early = $urandom_range(0, 1);
            good = exp_good(f, c);
            slotted_mode = sl;
            cyc(3);
            a0 = ack_cnt; i0 = irq_cnt;
            send_frame(f, c, rq);
            cyc(3);
            check(irq_cnt - i0 == int'(good), "R4 random irq", irq_cnt - i0, int'(good));
            if (good && rq) begin
                if (sl) begin
                    check(trac_code == 1, "R9 random wait code", trac_code, 1);
                    if (early) trig_pin = 1;
                    for (int k = 0; k < 3; k++) begin
                        tick();
                        cyc($urandom_range(0, 3));
                    end
                    if (!early) trig_pin = 1;
                    cyc(7);
                    check(ack_cnt - a0 == 1, "R10 random slotted ack", ack_cnt - a0, 1);
                    finish_ack();
                    set_pin(0);
                end else begin
                    check(ack_cnt - a0 == 1, "R6 random ack", ack_cnt - a0, 1);
                    finish_ack();
                end
            end else begin
                check(ack_cnt == a0, "R7 random no ack", ack_cnt - a0, 0);
                check(int'(trac_code) == exp_final_trac(good), "R12 random code",
                      trac_code, exp_final_trac(good));
            end
        end

        finished = 1;
        summary();
    end
endmodule